// File: doc/BRIEF.md
# Dual Full-Bridge Gate Sequencer with Asymmetric Dead Time

This block turns logic-level leg commands into separate high-side and low-side gate enables for two independent full bridges. Each bridge has two half-bridge legs. When a leg's command changes, the block first switches both of that leg's gates off. It then waits a fixed number of system clock cycles before it turns on the switch for the new level. The wait toward a high output and the wait toward a low output are separate parameters, so the dead time can differ by direction.

Each bridge has an active-low shutdown input. An undriven input is taken as low. While shutdown is low, both legs of that bridge are left floating with every switch off. A global disable from the protection sequencer and per-leg high-side and low-side overcurrent flags also force switches off. Shutdown and the global disable act on whole bridges. An overcurrent flag acts only on its own leg. After any of these conditions clears, a leg turns on only after a full dead-time interval in the direction it is commanded.

Top module: `hbridge_dt_ctrl`

## Requirements
- R1: While reset (active-low) is applied, and in the cycle after it is applied, every gate_hi, gate_lo and drv_en bit is 0.
- R2: While a bridge's shdn_n bit c is low, bits c*2 and c*2+1 of gate_hi, gate_lo and drv_en are all 0 from the next clock edge on. The other bridge does not change.
- R3: With its bridge enabled, a leg whose command has been steady high drives gate_hi=1 and gate_lo=0. A leg whose command has been steady low drives gate_lo=1 and gate_hi=0. drv_en is 1 whenever either gate of the leg is on.
- R4: Every leg follows only its own command and its own flags. Leg l belongs to bridge l/2.
- R5: When a leg's command goes from low to high, both of its gates are off for exactly DT_RISE clock cycles, and then gate_hi turns on.
- R6: When a leg's command goes from high to low, both of its gates are off for exactly DT_FALL clock cycles, and then gate_lo turns on.
- R7: If the command reverses before the dead-time wait ends, the wait restarts with the full interval for the new direction.
- R8: gate_hi and gate_lo of the same leg are never 1 in the same cycle.
- R9: While oc_hi[l] or oc_lo[l] is 1, leg l has both gates off from the next edge. The other legs are unaffected.
- R10: While gdis is 1, every leg has both gates off from the next edge.
- R11: After shutdown, disable, overcurrent or reset clears, a leg turns on its commanded gate only after the full dead time for that direction: DT_RISE cycles if the command is high, DT_FALL if it is low.
- R12: Commands toggling at 300 kHz (a half-period of 166 cycles at 100 MHz) are reproduced edge for edge, each one delayed by its dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_in | input | NUM_CH*LEGS_PER_CH | Per-leg level command, 1 = high side |
| shdn_n | input | NUM_CH | Per-bridge active-low shutdown; low floats the bridge |
| oc_hi | input | NUM_CH*LEGS_PER_CH | Per-leg high-side overcurrent flag |
| oc_lo | input | NUM_CH*LEGS_PER_CH | Per-leg low-side overcurrent flag |
| gdis | input | 1 | Global disable from the protection sequencer |
| gate_hi | output | NUM_CH*LEGS_PER_CH | High-side switch enable per leg |
| gate_lo | output | NUM_CH*LEGS_PER_CH | Low-side switch enable per leg |
| drv_en | output | NUM_CH*LEGS_PER_CH | Leg is driven (one switch on); 0 means high impedance |

## Verification
The bench checks that each dead time is exactly the right count in each direction. A design that swapped the two counts, or that was off by one cycle, would turn a gate on one cycle early or late. Commands are reversed in the middle of a dead time. A design that kept the old count would enable the new switch too soon, and a design that latched the old target would briefly drive the wrong side. The bench releases shutdown, overcurrent and the global disable while a command is held. A design that skipped the wait after release would switch on at once. The bench also applies one-leg and one-bridge faults. A design that shared the gating between legs would float a neighbour that should still be driven.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   // leg sequencing states
   typedef enum logic [1:0] {
      LEG_OFF  = 2'd0,
      LEG_WAIT = 2'd1,
      LEG_HI   = 2'd2,
      LEG_LO   = 2'd3
   } leg_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int DT_RISE = 20,
   parameter int DT_FALL = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd,
   input  logic blk,
   output logic gate_hi,
   output logic gate_lo
);

   localparam int DT_MAX = imax(DT_RISE, DT_FALL);
   localparam int CNT_W  = $clog2(DT_MAX + 1);
   localparam logic [CNT_W-1:0] LOAD_R = CNT_W'(DT_RISE - 1);
   localparam logic [CNT_W-1:0] LOAD_F = CNT_W'(DT_FALL - 1);

   leg_st_t          st;
   logic [CNT_W-1:0] cnt;
   logic             tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= LEG_OFF;
         cnt <= '0;
         tgt <= 1'b0;
      end else if (blk) begin
         st  <= LEG_OFF;
         cnt <= '0;
      end else begin
         unique case (st)
            LEG_OFF: begin
               st  <= LEG_WAIT;
               tgt <= cmd;
               cnt <= cmd ? LOAD_R : LOAD_F;
            end
            LEG_WAIT: begin
               if (cmd != tgt) begin
                  tgt <= cmd;
                  cnt <= cmd ? LOAD_R : LOAD_F;
               end else if (cnt == '0) begin
                  st <= tgt ? LEG_HI : LEG_LO;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            LEG_HI: begin
               if (!cmd) begin
                  st  <= LEG_WAIT;
                  tgt <= 1'b0;
                  cnt <= LOAD_F;
               end
            end
            LEG_LO: begin
               if (cmd) begin
                  st  <= LEG_WAIT;
                  tgt <= 1'b1;
                  cnt <= LOAD_R;
               end
            end
            default: st <= LEG_OFF;
         endcase
      end
   end

   assign gate_hi = (st == LEG_HI);
   assign gate_lo = (st == LEG_LO);

   // count of cycles both gates have been off, used by the dead-time checks
   logic [CNT_W:0] off_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      off_run <= '0;
      else if (gate_hi || gate_lo)     off_run <= '0;
      else if (off_run != '1)          off_run <= off_run + 1'b1;
   end

   // R8
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   // R5
   rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> (off_run >= (CNT_W+1)'(DT_RISE)));

   // R6
   fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> (off_run >= (CNT_W+1)'(DT_FALL)));

   // R9
   blk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk |=> !(gate_hi || gate_lo));

   // R3
   side_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi && cmd && !blk) |=> gate_hi);

endmodule

// File: rtl/hbg_chan.sv
module hbg_chan #(
   parameter int LEGS    = 2,
   parameter int DT_RISE = 20,
   parameter int DT_FALL = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LEGS-1:0] cmd,
   input  logic            shdn_n,
   input  logic [LEGS-1:0] oc_hi,
   input  logic [LEGS-1:0] oc_lo,
   input  logic            gdis,
   output logic [LEGS-1:0] gate_hi,
   output logic [LEGS-1:0] gate_lo,
   output logic [LEGS-1:0] drv_en
);

   logic [LEGS-1:0] blk;

   for (genvar j = 0; j < LEGS; j++) begin : g_leg
      assign blk[j] = !shdn_n || gdis || oc_hi[j] || oc_lo[j];

      hbg_leg #(
         .DT_RISE(DT_RISE),
         .DT_FALL(DT_FALL)
      ) u_leg (
         .clk    (clk),
         .rst_n  (rst_n),
         .cmd    (cmd[j]),
         .blk    (blk[j]),
         .gate_hi(gate_hi[j]),
         .gate_lo(gate_lo[j])
      );

      assign drv_en[j] = gate_hi[j] | gate_lo[j];
   end

   // R2
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (drv_en == '0));

   // R10
   gdis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gdis |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: rtl/hbridge_dt_ctrl.sv
module hbridge_dt_ctrl #(
   parameter int NUM_CH      = 2,
   parameter int LEGS_PER_CH = 2,
   parameter int DT_RISE     = 20,
   parameter int DT_FALL     = 18
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CH*LEGS_PER_CH-1:0] leg_in,
   input  logic [NUM_CH-1:0]             shdn_n,
   input  logic [NUM_CH*LEGS_PER_CH-1:0] oc_hi,
   input  logic [NUM_CH*LEGS_PER_CH-1:0] oc_lo,
   input  logic                          gdis,
   output logic [NUM_CH*LEGS_PER_CH-1:0] gate_hi,
   output logic [NUM_CH*LEGS_PER_CH-1:0] gate_lo,
   output logic [NUM_CH*LEGS_PER_CH-1:0] drv_en
);

   localparam int NLEG = NUM_CH * LEGS_PER_CH;

   if (NUM_CH < 1 || LEGS_PER_CH < 1) begin : g_bad_shape
      $error("hbridge_dt_ctrl: channel and leg counts must be at least 1");
   end
   if (DT_RISE < 1 || DT_FALL < 1) begin : g_bad_dt
      $error("hbridge_dt_ctrl: dead-time counts must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int B = c * LEGS_PER_CH;

      hbg_chan #(
         .LEGS   (LEGS_PER_CH),
         .DT_RISE(DT_RISE),
         .DT_FALL(DT_FALL)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .cmd    (leg_in[B +: LEGS_PER_CH]),
         .shdn_n (shdn_n[c]),
         .oc_hi  (oc_hi[B +: LEGS_PER_CH]),
         .oc_lo  (oc_lo[B +: LEGS_PER_CH]),
         .gdis   (gdis),
         .gate_hi(gate_hi[B +: LEGS_PER_CH]),
         .gate_lo(gate_lo[B +: LEGS_PER_CH]),
         .drv_en (drv_en[B +: LEGS_PER_CH])
      );
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (gate_hi == '0 && gate_lo == '0 && drv_en == '0));

   // R8
   all_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == {NLEG{1'b0}});

endmodule

// File: tb/sim_hbridge_dt_ctrl.sv
module sim_hbridge_dt_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int LPC = 2;
   localparam int NL  = NCH * LPC;
   localparam int DTR = 20;
   localparam int DTF = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] leg_in = '0;
   logic [NCH-1:0] shdn_n = '0;
   logic [NL-1:0] oc_hi = '0;
   logic [NL-1:0] oc_lo = '0;
   logic          gdis = 1'b0;
   logic [NL-1:0] gate_hi, gate_lo, drv_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_dt_ctrl #(
      .NUM_CH(NCH), .LEGS_PER_CH(LPC), .DT_RISE(DTR), .DT_FALL(DTF)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .leg_in(leg_in), .shdn_n(shdn_n),
      .oc_hi(oc_hi), .oc_lo(oc_lo), .gdis(gdis),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .drv_en(drv_en)
   );

   // behavioural reference: a leg drives once its unblocked command has
   // been held for more than its dead time in clock edges
   int run  [NL];
   bit lastc[NL];

   function automatic bit blocked(int l);
      return !shdn_n[l / LPC] || gdis || oc_hi[l] || oc_lo[l];
   endfunction

   always @(posedge clk) begin
      for (int l = 0; l < NL; l++) begin
         if (!rst_n || blocked(l)) begin
            run[l] = 0;
         end else begin
            if (run[l] > 0 && leg_in[l] == lastc[l]) begin
               if (run[l] < 100000) run[l] = run[l] + 1;
            end else begin
               run[l] = 1;
            end
            lastc[l] = leg_in[l];
         end
      end
   end

   int    vecs = 0;
   int    errs = 0;
   string ph = "R1";

   task automatic compare_all();
      for (int l = 0; l < NL; l++) begin
         bit eh, el, ee;
         eh = lastc[l] && (run[l] >= DTR + 1);
         el = !lastc[l] && (run[l] >= DTF + 1);
         ee = eh | el;
         vecs++;
         if (gate_hi[l] !== eh || gate_lo[l] !== el || drv_en[l] !== ee) begin
            errs++;
            $display("FAIL %s leg %0d: hi/lo/en=%b%b%b expected %b%b%b",
                     ph, l, gate_hi[l], gate_lo[l], drv_en[l], eh, el, ee);
         end
         vecs++;
         if (gate_hi[l] === 1'b1 && gate_lo[l] === 1'b1) begin  // R8
            errs++;
            $display("FAIL R8 leg %0d: hi/lo=11 expected not both", l);
         end
      end
   endtask

   task automatic step(int n);
      repeat (n) begin
         @(negedge clk);
         compare_all();
      end
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin run[l] = 0; lastc[l] = 0; end
      // R1: reset state
      ph = "R1";
      step(4);
      rst_n = 1'b1;
      shdn_n = '1;
      // R11: first enable after reset waits full fall dead time
      ph = "R11";
      step(30);
      // R5: rising dead time on leg 0
      ph = "R5";
      leg_in[0] = 1'b1;
      step(30);
      // R6: falling dead time on leg 0
      ph = "R6";
      leg_in[0] = 1'b0;
      step(30);
      // R4 / R3: independent legs with differing commands
      ph = "R4";
      leg_in = 4'b1010;
      step(5);
      leg_in = 4'b0110;
      step(30);
      ph = "R3";
      step(10);
      // R7: reversal mid-wait
      ph = "R7";
      leg_in[0] = 1'b1;
      step(7);
      leg_in[0] = 1'b0;
      step(5);
      leg_in[0] = 1'b1;
      step(30);
      // R2: shutdown of bridge 0 only
      ph = "R2";
      shdn_n[0] = 1'b0;
      step(12);
      ph = "R11";
      shdn_n[0] = 1'b1;
      step(30);
      // R9: overcurrent on single legs
      ph = "R9";
      oc_hi[2] = 1'b1;
      step(6);
      oc_hi[2] = 1'b0;
      oc_lo[3] = 1'b1;
      step(6);
      oc_lo[3] = 1'b0;
      ph = "R11";
      step(30);
      // R10: global disable
      ph = "R10";
      gdis = 1'b1;
      step(8);
      gdis = 1'b0;
      ph = "R11";
      leg_in = 4'b1001;
      step(30);
      // R12: 300 kHz toggling on legs 1 and 2
      ph = "R12";
      for (int k = 0; k < 8; k++) begin
         leg_in[1] = ~leg_in[1];
         leg_in[2] = ~leg_in[2];
         step(166);
      end
      // R1: reset reapplied mid-run
      ph = "R1";
      rst_n = 1'b0;
      step(3);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule